// File: doc/BRIEF.md
# Dual Command Queue Conversion Arbiter

This block decides which of two command queues gets to use a single shared converter. Each queue walks a window of a 64-entry command memory. The window is set by a first and a last pointer. The queue starts when one of its trigger inputs fires, and it issues its commands one at a time onto the converter. A command word carries a channel number in its low bits and a stop flag in its top bit. When a command with the stop flag finishes, the queue halts as it would at the last command. The next trigger then resumes it at the command that follows.

The first queue has priority. Whenever the converter is free and both queues have a command waiting, the first queue's command is issued. A conversion that has started is always allowed to finish. A trigger for the first queue therefore takes effect at the next command boundary, and the second queue later carries on from the command where it was overtaken. If a trigger arrives while its queue is already busy, the block raises a one-cycle overrun flag and otherwise ignores the trigger. In continuous mode, finishing the last command acts as a fresh trigger for the same queue.

Top module: `cqa_top`

## Requirements
- R1: After reset both status outputs read 0 (idle), and conv_start and both overrun flags are low.
- R2: A trigger to an idle or complete queue issues commands from its first pointer to its last pointer in address order, wrapping from 63 to 0. After the last command is done the status reads 4 (complete).
- R3: Queue 1 is triggered by q1_ext_trig or q1_sw_trig. Queue 2 is triggered by q2_ext_trig, q2_sw_trig or q2_timer_tick.
- R4: Bit 7 of the command word is the stop flag. When a command with the flag set is done, its queue reads 3 (paused), and its next trigger resumes it at the following address. If the flagged command is the last command, the queue reads 4 instead.
- R5: When both queues are pending (status 1) and the converter is free, queue 1's command is issued.
- R6: A started conversion is never cut short. A queue 2 overtaken at a command boundary later resumes at the next command it had not yet issued, so no command is skipped or repeated.
- R7: conv_start is a one-cycle pulse. No new conv_start is issued before conv_done for the outstanding conversion, and the two are never in the same cycle.
- R8: A trigger arriving while its queue reads 1 (pending) or 2 (active) raises that queue's overrun flag for exactly one cycle. It does not change the command sequence.
- R9: With the queue's continuous input high, finishing the last command restarts the queue at its first pointer without a trigger.
- R10: At conv_start, conv_chan holds bits 5:0 of the command word, and conv_queue holds 0 for queue 1 or 1 for queue 2. The status of that queue reads 2 (active) until its conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q1_ext_trig | input | 1 | Queue 1 external trigger pulse |
| q1_sw_trig | input | 1 | Queue 1 software single-scan pulse |
| q2_ext_trig | input | 1 | Queue 2 external trigger pulse |
| q2_sw_trig | input | 1 | Queue 2 software single-scan pulse |
| q2_timer_tick | input | 1 | Queue 2 interval timer expiry pulse |
| q1_cont | input | 1 | Queue 1 continuous mode |
| q2_cont | input | 1 | Queue 2 continuous mode |
| q1_start_ptr | input | 6 | Queue 1 first command address |
| q1_end_ptr | input | 6 | Queue 1 last command address |
| q2_start_ptr | input | 6 | Queue 2 first command address |
| q2_end_ptr | input | 6 | Queue 2 last command address |
| cmd_addr | output | 6 | Command memory read address |
| cmd_data | input | 8 | Command word at cmd_addr (same cycle) |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 6 | Channel of the issued command |
| conv_queue | output | 1 | Queue that owns the issued command |
| conv_done | input | 1 | Converter finished pulse |
| q1_status | output | 3 | Queue 1 state: 0 idle, 1 pending, 2 active, 3 paused, 4 complete |
| q2_status | output | 3 | Queue 2 state, same encoding |
| q1_overrun | output | 1 | Queue 1 trigger overrun pulse |
| q2_overrun | output | 1 | Queue 2 trigger overrun pulse |

## Verification
The properties assume that conv_done pulses only while a conversion is outstanding, that it pulses for one cycle, and that cmd_data answers cmd_addr in the same cycle. The converter model in the bench raises conv_done a fixed number of cycles after each conv_start. The memory model is a function of the address. Triggers are pulses placed at chosen points relative to the running sequence: while a conversion is in flight, in the same cycle for both queues, or while a queue is paused or complete. This is how the overtaking and overrun cases arise in a repeatable way.

// File: rtl/cqa_pkg.sv
package cqa_pkg;
  typedef enum logic [2:0] {
    QS_IDLE = 3'd0,
    QS_PEND = 3'd1,
    QS_ACTV = 3'd2,
    QS_PAUS = 3'd3,
    QS_DONE = 3'd4
  } qstate_e;
endpackage

// File: rtl/cqa_queue.sv
module cqa_queue
  import cqa_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          cont_i,
  input  logic [AW-1:0] start_ptr_i,
  input  logic [AW-1:0] end_ptr_i,
  input  logic          grant_i,
  input  logic          done_i,
  input  logic          done_pause_i,
  input  logic          done_last_i,
  output logic [AW-1:0] ptr_o,
  output qstate_e       state_o,
  output logic          ovr_o
);
  qstate_e       state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ovr_q, ovr_d;
  logic          upd_en;

  assign upd_en = trig_i | grant_i | done_i;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    ovr_d   = 1'b0;
    case (state_q)
      QS_IDLE, QS_DONE: begin
        if (trig_i) begin
          state_d = QS_PEND;
          ptr_d   = start_ptr_i;
        end
      end
      QS_PAUS: begin
        if (trig_i) state_d = QS_PEND;
      end
      QS_PEND: begin
        ovr_d = trig_i;
        if (grant_i) state_d = QS_ACTV;
      end
      QS_ACTV: begin
        ovr_d = trig_i;
        if (done_i) begin
          if (done_last_i) begin
            if (cont_i) begin
              state_d = QS_PEND;
              ptr_d   = start_ptr_i;
            end else begin
              state_d = QS_DONE;
            end
          end else begin
            ptr_d   = ptr_q + 1'b1;
            state_d = done_pause_i ? QS_PAUS : QS_PEND;
          end
        end
      end
      default: state_d = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      ptr_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      if (upd_en) begin
        state_q <= state_d;
        ptr_q   <= ptr_d;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign state_o = state_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/cqa_pick.sv
module cqa_pick #(
  parameter int NQ = 2,
  parameter int QW = 1
) (
  input  logic          free_i,
  input  logic [NQ-1:0] pend_i,
  output logic [QW-1:0] gsel_o,
  output logic          grant_any_o,
  output logic [NQ-1:0] grant_o
);
  logic any_pend;

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    gsel_o   = '0;
    any_pend = 1'b0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        gsel_o   = QW'(i);
        any_pend = 1'b1;
      end
    end
  end

  assign grant_any_o = free_i & any_pend;

  for (genvar g = 0; g < NQ; g++) begin : g_grant
    assign grant_o[g] = grant_any_o & (gsel_o == QW'(g));
  end
endmodule

// File: rtl/cqa_issue.sv
module cqa_issue #(
  parameter int NQ        = 2,
  parameter int QW        = 1,
  parameter int CMD_W     = 8,
  parameter int CHAN_W    = 6,
  parameter int PAUSE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_any_i,
  input  logic [QW-1:0]     gsel_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              is_last_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic [QW-1:0]     conv_queue_o,
  output logic              busy_o,
  output logic [NQ-1:0]     done_o,
  output logic              done_pause_o,
  output logic              done_last_o
);
  logic              busy_q, busy_d;
  logic              start_q;
  logic [CHAN_W-1:0] chan_q;
  logic [QW-1:0]     cur_q;
  logic              pause_q, last_q;
  logic              fin;

  assign fin = busy_q & conv_done_i;

  always_comb begin
    busy_d = busy_q;
    if (grant_any_i)
      busy_d = 1'b1;
    else if (fin)
      busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
      cur_q   <= '0;
      pause_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= grant_any_i;
      if (grant_any_i) begin
        chan_q  <= cmd_i[CHAN_W-1:0];
        cur_q   <= gsel_i;
        pause_q <= cmd_i[PAUSE_BIT];
        last_q  <= is_last_i;
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_done
    assign done_o[g] = fin & (cur_q == QW'(g));
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign conv_queue_o = cur_q;
  assign busy_o       = busy_q;
  assign done_pause_o = pause_q;
  assign done_last_o  = last_q;
endmodule

// File: rtl/cqa_top.sv
module cqa_top
  import cqa_pkg::*;
#(
  parameter int AW        = 6,
  parameter int CMD_W     = 8,
  parameter int CHAN_W    = 6,
  parameter int PAUSE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q1_ext_trig,
  input  logic              q1_sw_trig,
  input  logic              q2_ext_trig,
  input  logic              q2_sw_trig,
  input  logic              q2_timer_tick,
  input  logic              q1_cont,
  input  logic              q2_cont,
  input  logic [AW-1:0]     q1_start_ptr,
  input  logic [AW-1:0]     q1_end_ptr,
  input  logic [AW-1:0]     q2_start_ptr,
  input  logic [AW-1:0]     q2_end_ptr,
  output logic [AW-1:0]     cmd_addr,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_queue,
  input  logic              conv_done,
  output logic [2:0]        q1_status,
  output logic [2:0]        q2_status,
  output logic              q1_overrun,
  output logic              q2_overrun
);
  localparam int NQ = 2;
  localparam int QW = $clog2(NQ);

  logic [1:0]    rsync_q;
  logic          rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [NQ-1:0] trig, cont, pend, grant, done, ovr;
  logic [AW-1:0] sptr [NQ];
  logic [AW-1:0] eptr [NQ];
  logic [AW-1:0] ptr  [NQ];
  qstate_e       st   [NQ];
  logic [QW-1:0] gsel;
  logic          grant_any, busy, done_pause, done_last, is_last;

  assign trig[0] = q1_ext_trig | q1_sw_trig;
  assign trig[1] = q2_ext_trig | q2_sw_trig | q2_timer_tick;
  assign cont    = {q2_cont, q1_cont};
  assign sptr[0] = q1_start_ptr;
  assign sptr[1] = q2_start_ptr;
  assign eptr[0] = q1_end_ptr;
  assign eptr[1] = q2_end_ptr;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    cqa_queue #(.AW(AW)) u_queue (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .trig_i       (trig[g]),
      .cont_i       (cont[g]),
      .start_ptr_i  (sptr[g]),
      .end_ptr_i    (eptr[g]),
      .grant_i      (grant[g]),
      .done_i       (done[g]),
      .done_pause_i (done_pause),
      .done_last_i  (done_last),
      .ptr_o        (ptr[g]),
      .state_o      (st[g]),
      .ovr_o        (ovr[g])
    );
    assign pend[g] = (st[g] == QS_PEND);
  end

  cqa_pick #(.NQ(NQ), .QW(QW)) u_pick (
    .free_i      (~busy),
    .pend_i      (pend),
    .gsel_o      (gsel),
    .grant_any_o (grant_any),
    .grant_o     (grant)
  );

  assign cmd_addr = ptr[gsel];
  assign is_last  = (ptr[gsel] == eptr[gsel]);

  cqa_issue #(
    .NQ(NQ), .QW(QW), .CMD_W(CMD_W), .CHAN_W(CHAN_W), .PAUSE_BIT(PAUSE_BIT)
  ) u_issue (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .grant_any_i  (grant_any),
    .gsel_i       (gsel),
    .cmd_i        (cmd_data),
    .is_last_i    (is_last),
    .conv_done_i  (conv_done),
    .conv_start_o (conv_start),
    .conv_chan_o  (conv_chan),
    .conv_queue_o (conv_queue),
    .busy_o       (busy),
    .done_o       (done),
    .done_pause_o (done_pause),
    .done_last_o  (done_last)
  );

  assign q1_status  = st[0];
  assign q2_status  = st[1];
  assign q1_overrun = ovr[0];
  assign q2_overrun = ovr[1];
endmodule

// File: rtl/cqa_chk.sv
module cqa_chk
  import cqa_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start,
  input logic       conv_queue,
  input logic       conv_done,
  input logic [2:0] q1_status,
  input logic [2:0] q2_status,
  input logic       q1_overrun,
  input logic       q2_overrun
);
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R7
  start_done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && conv_done));
  // R7
  single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_status == QS_ACTV && q2_status == QS_ACTV));
  // R5
  q1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_queue) |-> ($past(q1_status) != QS_PEND));
  // R10
  owner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ((conv_queue ? q2_status : q1_status) == QS_ACTV));
  // R8
  q1_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q1_overrun |-> ($past(q1_status) == QS_PEND || $past(q1_status) == QS_ACTV));
  // R8
  q2_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q2_overrun |-> ($past(q2_status) == QS_PEND || $past(q2_status) == QS_ACTV));
  // R2
  q1_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_status == QS_DONE && $past(q1_status) != QS_DONE) |-> $past(q1_status) == QS_ACTV);
  // R4
  q2_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q2_status == QS_PAUS && $past(q2_status) != QS_PAUS) |-> $past(q2_status) == QS_ACTV);
  // R7 (input assumption: done only while a conversion is outstanding)
  done_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (q1_status == QS_ACTV || q2_status == QS_ACTV));
endmodule

bind cqa_top cqa_chk u_cqa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_queue (conv_queue),
  .conv_done  (conv_done),
  .q1_status  (q1_status),
  .q2_status  (q2_status),
  .q1_overrun (q1_overrun),
  .q2_overrun (q2_overrun)
);

// File: tb/test_cqa_top.sv
module test_cqa_top;
  logic       clk, rst_n;
  logic       q1_ext, q1_sw, q2_ext, q2_sw, q2_tmr, q1_cont, q2_cont;
  logic [5:0] q1_s, q1_e, q2_s, q2_e, cmd_addr, conv_chan;
  logic [7:0] cmd_data;
  logic       conv_start, conv_queue, conv_done, q1_ovr, q2_ovr;
  logic [2:0] q1_st, q2_st;

  int checks, errors;
  int log_q [256]; int log_c [256]; int log_n;
  int exp_q [256]; int exp_c [256]; int exp_n;
  int cnt, ovr1, ovr2, overlap;

  cqa_top i_cqa_top (
    .clk(clk), .rst_n(rst_n),
    .q1_ext_trig(q1_ext), .q1_sw_trig(q1_sw),
    .q2_ext_trig(q2_ext), .q2_sw_trig(q2_sw), .q2_timer_tick(q2_tmr),
    .q1_cont(q1_cont), .q2_cont(q2_cont),
    .q1_start_ptr(q1_s), .q1_end_ptr(q1_e),
    .q2_start_ptr(q2_s), .q2_end_ptr(q2_e),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_queue(conv_queue),
    .conv_done(conv_done),
    .q1_status(q1_st), .q2_status(q2_st),
    .q1_overrun(q1_ovr), .q2_overrun(q2_ovr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // command memory: stop flag (bit 7) at 21 and 45, channel = address
  assign cmd_data = {(cmd_addr == 6'd21 || cmd_addr == 6'd45), 1'b0, cmd_addr};

  // converter model: done three cycles after start; logging of issues
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; conv_done = 1'b0;
    end else begin
      conv_done = 1'b0;
      if (cnt > 0) begin
        if (cnt == 1) conv_done = 1'b1;
        cnt = cnt - 1;
      end
      if (conv_start) begin
        if (cnt != 0 || conv_done) overlap++;
        log_q[log_n] = conv_queue; log_c[log_n] = conv_chan; log_n++;
        cnt = 3;
      end
      if (q1_ovr) ovr1++;
      if (q2_ovr) ovr2++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int q, input int s, input int e);
    int a = s;
    forever begin
      exp_q[exp_n] = q; exp_c[exp_n] = a; exp_n++;
      if (a == e) break;
      a = (a + 1) % 64;
    end
  endtask

  task automatic fresh();
    log_n = 0; exp_n = 0;
  endtask

  // src: 0 q1 ext, 1 q1 sw, 2 q2 ext, 3 q2 sw, 4 q2 timer, 5 both ext
  task automatic pulse(input int src);
    case (src)
      0: q1_ext = 1'b1;
      1: q1_sw  = 1'b1;
      2: q2_ext = 1'b1;
      3: q2_sw  = 1'b1;
      4: q2_tmr = 1'b1;
      default: begin q1_ext = 1'b1; q2_ext = 1'b1; end
    endcase
    @(negedge clk);
    q1_ext = 0; q1_sw = 0; q2_ext = 0; q2_sw = 0; q2_tmr = 0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    forever begin
      @(negedge clk);
      if (q1_st != 1 && q1_st != 2 && q2_st != 1 && q2_st != 2 &&
          cnt == 0 && !conv_start && !conv_done) break;
      t++;
      if (t > 3000) begin
        check(0, req, "idle timeout", t, 0);
        break;
      end
    end
  endtask

  task automatic compare(input string req);
    check(log_n == exp_n, req, "issue count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_q[i] == exp_q[i], req, "queue", log_q[i], exp_q[i]);
      check(log_c[i] == exp_c[i], req, "channel", log_c[i], exp_c[i]);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ss [5] = '{4, 0, 62, 17, 34};
    int ee [5] = '{7, 0, 1, 18, 40};
    checks = 0; errors = 0; log_n = 0; exp_n = 0;
    ovr1 = 0; ovr2 = 0; overlap = 0; cnt = 0;
    q1_ext = 0; q1_sw = 0; q2_ext = 0; q2_sw = 0; q2_tmr = 0;
    q1_cont = 0; q2_cont = 0;
    q1_s = 0; q1_e = 0; q2_s = 0; q2_e = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(q1_st == 0 && q2_st == 0, "R1", "status idle", {q1_st, q2_st}, 0);
    check(!conv_start && !q1_ovr && !q2_ovr, "R1", "outputs low",
          {conv_start, q1_ovr, q2_ovr}, 0);

    // R2/R3/R10 sweep of queue 1 windows, alternating ext and sw triggers
    for (int k = 0; k < 5; k++) begin
      fresh();
      q1_s = 6'(ss[k]); q1_e = 6'(ee[k]);
      push(0, ss[k], ee[k]);
      pulse(k % 2);
      wait_idle("R2");
      compare("R2 R3 R10 q1 window");
      check(q1_st == 4, "R2", "q1 complete", q1_st, 4);
    end

    // R4 pause via timer trigger, resume via sw trigger (R3)
    fresh();
    q2_s = 44; q2_e = 47;
    push(1, 44, 45);
    pulse(4);
    wait_idle("R4");
    compare("R4 pause stop");
    check(q2_st == 3, "R4", "q2 paused", q2_st, 3);
    fresh();
    push(1, 46, 47);
    pulse(3);
    wait_idle("R4");
    compare("R4 resume");
    check(q2_st == 4, "R4", "q2 complete", q2_st, 4);

    // R4 stop flag on last command
    fresh();
    q2_s = 45; q2_e = 45;
    push(1, 45, 45);
    pulse(2);
    wait_idle("R4");
    compare("R4 stop on last");
    check(q2_st == 4, "R4", "last wins over stop", q2_st, 4);

    // R5/R6 queue 1 overtakes queue 2 at a boundary
    fresh();
    q1_s = 4; q1_e = 5; q2_s = 30; q2_e = 35;
    push(1, 30, 30); push(0, 4, 5); push(1, 31, 35);
    pulse(2);
    repeat (1) @(negedge clk);
    pulse(0);
    wait_idle("R6");
    compare("R5 R6 overtake");

    // R5 simultaneous triggers
    fresh();
    q1_s = 10; q1_e = 12; q2_s = 50; q2_e = 52;
    push(0, 10, 12); push(1, 50, 52);
    pulse(5);
    wait_idle("R5");
    compare("R5 simultaneous");

    // R8 overrun while running
    fresh();
    ovr1 = 0; ovr2 = 0;
    q1_s = 0; q1_e = 3;
    push(0, 0, 3);
    pulse(0);
    repeat (2) @(negedge clk);
    pulse(1);
    wait_idle("R8");
    compare("R8 sequence unchanged");
    check(ovr1 == 1, "R8", "q1 overrun pulses", ovr1, 1);
    check(ovr2 == 0, "R8", "q2 overrun pulses", ovr2, 0);

    // R9 continuous mode
    fresh();
    q1_s = 8; q1_e = 9; q1_cont = 1'b1;
    push(0, 8, 9); push(0, 8, 9); push(0, 8, 9);
    pulse(0);
    while (log_n < 6) @(posedge clk);
    @(negedge clk);
    q1_cont = 1'b0;
    wait_idle("R9");
    compare("R9 continuous");
    check(q1_st == 4, "R9", "q1 complete after cont off", q1_st, 4);

    // R7 no overlap between conversions across the whole run
    check(overlap == 0, "R7", "overlapping starts", overlap, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule